// File: doc/BRIEF.md
# Disk Channel Interrupt Status Register

This block gathers the two interrupt sources of a single disk channel into one small register set. The first source is the channel interrupt, raised when the attached device finishes a command or a transfer. The second is a host bus error seen while the channel moves data by DMA. Each source has a pending bit and an enable bit. The interrupt line to the host is high whenever a pending bit and its enable bit are both set.

When a bus error is first reported, the block captures the 64-bit faulting address. Software reads it as two 32-bit words. Pending bits clear in two ways. Software can write ones to the status word. The bits also clear on their own when the device status byte is read while the device is not busy.

The register space is word-addressed with single-cycle writes. Reads are combinational from the addressed word and have no side effects.

Top module: `ist_irq_status`

## Requirements
- R1: After synchronous reset, both pending bits, both enable bits and the captured error address are zero, and `host_irq` is low.
- R2: A pulse on `chan_irq_evt` sets pending bit 0 and a pulse on `bus_err_evt` sets pending bit 1. The status word at offset 3 reads pending in bits [1:0] and zero above them.
- R3: A write to offset 3 clears each pending bit whose position in `reg_wdata[1:0]` is one. Writing 0x03 clears both bits, and zero positions are left unchanged.
- R4: A write to offset 5 sets each enable bit whose position in `reg_wdata[1:0]` is one. Offsets 5 and 7 both read the enable bits in bits [1:0].
- R5: A write to offset 7 clears each enable bit whose position in `reg_wdata[1:0]` is one.
- R6: `host_irq` is high exactly while pending AND enable is nonzero. It drops in the cycle after the clear, or after the disable, takes effect.
- R7: A cycle with `dev_stat_rd` high and `dev_stat[7]` (busy) low clears both pending bits. When busy is high, the read has no effect.
- R8: If an event and a clear of the same bit fall in one cycle, whether the clear comes from a status write or from a status read, the bit ends up set.
- R9: A bus error that arrives while pending bit 1 is clear, or is being cleared in the same cycle, captures `bus_err_addr`. Offset 0 reads the low 32 bits of the captured address and offset 1 reads the high 32 bits.
- R10: While pending bit 1 stays set, further bus errors leave the captured address unchanged.
- R11: Offsets 2, 4 and 6 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Word offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at `reg_addr` |
| chan_irq_evt | input | 1 | Channel interrupt event pulse |
| bus_err_evt | input | 1 | Host bus error during DMA, pulse |
| bus_err_addr | input | 64 | Faulting address, valid with `bus_err_evt` |
| dev_stat_rd | input | 1 | Device status byte is being read this cycle |
| dev_stat | input | 8 | Device status byte; bit 7 is busy |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
The hardest cases to reach are those where a new event meets a clear in the same cycle. Two of them matter most. One is a bus error that arrives together with a write-one-to-clear of bit 1, which must capture the new address and not keep the old one. The other is a channel event that coincides with a non-busy status read. The stimulus drives both inputs in one clock on purpose. It then reads the status word and the two address words to confirm that the event won and that the capture rule followed the cleared state. It also sends a second bus error while the first is still pending, to show that the address is held.

// File: rtl/ist_pkg.sv
package ist_pkg;

    localparam int NSRC       = 2;
    localparam int SRC_CHAN   = 0;
    localparam int SRC_BUSERR = 1;

    localparam int OFF_ERR_LO = 0;
    localparam int OFF_ERR_HI = 1;
    localparam int OFF_PEND   = 3;
    localparam int OFF_EN_SET = 5;
    localparam int OFF_EN_CLR = 7;

    localparam int BUSY_BIT   = 7;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_ERR_LO,
        RSEL_ERR_HI,
        RSEL_PEND,
        RSEL_EN
    } rsel_e;

    typedef struct packed {
        logic     wr_pend;
        logic     wr_en_set;
        logic     wr_en_clr;
        src_vec_t wmask;
        rsel_e    rsel;
    } reg_op_t;

    function automatic rsel_e offset_to_rsel(input int unsigned off);
        case (off)
            OFF_ERR_LO: return RSEL_ERR_LO;
            OFF_ERR_HI: return RSEL_ERR_HI;
            OFF_PEND:   return RSEL_PEND;
            OFF_EN_SET,
            OFF_EN_CLR: return RSEL_EN;
            default:    return RSEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ist_decode.sv
module ist_decode
    import ist_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  src_vec_t          wbits,
    output reg_op_t           op
);
    int unsigned off;

    always_comb begin
        off          = int'(reg_addr);
        op.rsel      = offset_to_rsel(off);
        op.wmask     = wbits;
        op.wr_pend   = reg_wr && (off == OFF_PEND);
        op.wr_en_set = reg_wr && (off == OFF_EN_SET);
        op.wr_en_clr = reg_wr && (off == OFF_EN_CLR);
    end
endmodule

// File: rtl/ist_src_bit.sv
module ist_src_bit (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= (pend & ~clr) | evt;
    end
endmodule

// File: rtl/ist_err_capture.sv
module ist_err_capture #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          err_evt,
    input  logic          err_pend,
    input  logic          err_clr,
    input  logic [AW-1:0] err_addr_in,
    output logic [AW-1:0] err_addr_q
);
    logic held;
    assign held = err_pend & ~err_clr;

    always_ff @(posedge clk) begin
        if (rst)                  err_addr_q <= '0;
        else if (err_evt && !held) err_addr_q <= err_addr_in;
    end
endmodule

// File: rtl/ist_irq_status.sv
module ist_irq_status
    import ist_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                chan_irq_evt,
    input  logic                bus_err_evt,
    input  logic [2*DATA_W-1:0] bus_err_addr,
    input  logic                dev_stat_rd,
    input  logic [7:0]          dev_stat,
    output logic                host_irq
);
    localparam int ERR_W = 2 * DATA_W;

    reg_op_t          op;
    src_vec_t         evt_vec;
    src_vec_t         clr_vec;
    src_vec_t         pend_q;
    src_vec_t         en_q;
    logic             idle_read;
    logic [ERR_W-1:0] err_q;
    logic             unused_bits;

    assign unused_bits = ^{reg_wdata[DATA_W-1:NSRC], dev_stat[BUSY_BIT-1:0]};

    ist_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .wbits    (reg_wdata[NSRC-1:0]),
        .op       (op)
    );

    assign idle_read = dev_stat_rd & ~dev_stat[BUSY_BIT];

    always_comb begin
        evt_vec             = '0;
        evt_vec[SRC_CHAN]   = chan_irq_evt;
        evt_vec[SRC_BUSERR] = bus_err_evt;
        clr_vec             = (op.wr_pend ? op.wmask : '0) | {NSRC{idle_read}};
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        ist_src_bit u_bit (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt_vec[g]),
            .clr  (clr_vec[g]),
            .pend (pend_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)               en_q <= '0;
        else if (op.wr_en_set) en_q <= en_q | op.wmask;
        else if (op.wr_en_clr) en_q <= en_q & ~op.wmask;
    end

    ist_err_capture #(.AW(ERR_W)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .err_evt     (bus_err_evt),
        .err_pend    (pend_q[SRC_BUSERR]),
        .err_clr     (clr_vec[SRC_BUSERR]),
        .err_addr_in (bus_err_addr),
        .err_addr_q  (err_q)
    );

    always_comb begin
        reg_rdata = '0;
        case (op.rsel)
            RSEL_ERR_LO: reg_rdata = err_q[DATA_W-1:0];
            RSEL_ERR_HI: reg_rdata = err_q[ERR_W-1:DATA_W];
            RSEL_PEND:   reg_rdata[NSRC-1:0] = pend_q;
            RSEL_EN:     reg_rdata[NSRC-1:0] = en_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign host_irq = |(pend_q & en_q);

endmodule

// File: rtl/ist_checker.sv
module ist_checker #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                chan_irq_evt,
    input logic                bus_err_evt,
    input logic [2*DATA_W-1:0] bus_err_addr,
    input logic                dev_stat_rd,
    input logic [7:0]          dev_stat,
    input logic [1:0]          pend_q,
    input logic [2*DATA_W-1:0] err_q,
    input logic                host_irq
);
    logic idle_rd;
    logic clr1;
    assign idle_rd = dev_stat_rd && !dev_stat[7];
    assign clr1 = (reg_wr && reg_addr == 3'd3 && reg_wdata[1]) || idle_rd;

    a_r2_chan_sets: assert property (@(posedge clk) disable iff (rst)
        chan_irq_evt |=> pend_q[0]);

    a_r8_buserr_wins: assert property (@(posedge clk) disable iff (rst)
        bus_err_evt |=> pend_q[1]);

    a_r3_w1c_bit0: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd3 && reg_wdata[0] && !chan_irq_evt) |=> !pend_q[0]);

    a_r7_idle_read_clears: assert property (@(posedge clk) disable iff (rst)
        (idle_rd && !chan_irq_evt && !bus_err_evt) |=> (pend_q == 2'b00));

    a_r9_capture: assert property (@(posedge clk) disable iff (rst)
        (bus_err_evt && !pend_q[1]) |=> (err_q == $past(bus_err_addr)));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (pend_q[1] && !clr1) |=> $stable(err_q));

    a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(host_irq) |-> $past(chan_irq_evt || bus_err_evt || (reg_wr && reg_addr == 3'd5)));

    a_r2_pend_source: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q[0]) |-> $past(chan_irq_evt));
endmodule

bind ist_irq_status ist_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .chan_irq_evt (chan_irq_evt),
    .bus_err_evt  (bus_err_evt),
    .bus_err_addr (bus_err_addr),
    .dev_stat_rd  (dev_stat_rd),
    .dev_stat     (dev_stat),
    .pend_q       (pend_q),
    .err_q        (err_q),
    .host_irq     (host_irq)
);

// File: tb/tb_ist_irq_status.sv
module tb_ist_irq_status;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        chan_irq_evt;
    logic        bus_err_evt;
    logic [63:0] bus_err_addr;
    logic        dev_stat_rd;
    logic [7:0]  dev_stat;
    logic        host_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ist_irq_status dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_irq_evt(chan_irq_evt), .bus_err_evt(bus_err_evt),
        .bus_err_addr(bus_err_addr), .dev_stat_rd(dev_stat_rd),
        .dev_stat(dev_stat), .host_irq(host_irq)
    );

    // vector: [12]chan [11]bus [10]wr [9:7]addr [6:5]wdata [4]stat_rd [3]busy [2:1]exp_pend [0]exp_irq
    localparam logic [12:0] VEC [16] = '{
        13'b0_0_1_101_11_0_0_00_0, // R4 enable both
        13'b1_0_0_000_00_0_0_01_1, // R2 chan
        13'b0_1_0_000_00_0_0_11_1, // R2 bus error
        13'b0_0_1_011_01_0_0_10_1, // R3 clear bit0
        13'b0_0_1_011_10_0_0_00_0, // R3 R6 clear bit1
        13'b1_0_1_011_01_0_0_01_1, // R8 event beats clear
        13'b0_0_0_000_00_1_1_01_1, // R7 busy read ignored
        13'b0_0_0_000_00_1_0_00_0, // R7 idle read clears
        13'b0_1_0_000_00_0_0_10_1, // R2 bus error
        13'b0_0_1_111_10_0_0_10_0, // R5 R6 disable bit1
        13'b1_0_0_000_00_0_0_11_1, // R6 chan still enabled
        13'b0_0_1_111_01_0_0_11_0, // R5 disable bit0
        13'b0_0_1_110_11_0_0_11_0, // R11 unmapped write
        13'b0_0_1_101_11_0_0_11_1, // R4 re-enable
        13'b0_1_0_000_00_1_0_10_1, // R8 bus error beats idle read
        13'b0_0_1_011_11_0_0_00_0  // R3 clear both
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_wdata = 0; chan_irq_evt = 0; bus_err_evt = 0;
        dev_stat_rd = 0; dev_stat = 8'h00;
    endtask

    task automatic cyc();
        @(posedge clk); #1; idle();
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic bus_err(input logic [63:0] a, input bit clr_too);
        @(negedge clk);
        bus_err_evt = 1; bus_err_addr = a;
        if (clr_too) begin reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'h2; end
        cyc();
    endtask

    task automatic chk_addr(input logic [63:0] e, input string tag);
        logic [31:0] lo, hi;
        rd(3'd0, lo); rd(3'd1, hi);
        chk({hi, lo} == e, tag, {hi, lo}, e);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(); reg_addr = 0; bus_err_addr = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk(d == 0, "R1 reset read", d, 0);
        end
        chk(host_irq == 0, "R1 reset irq", host_irq, 0);

        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chan_irq_evt = VEC[i][12];
            bus_err_evt  = VEC[i][11];
            reg_wr       = VEC[i][10];
            reg_addr     = VEC[i][9:7];
            reg_wdata    = {30'd0, VEC[i][6:5]};
            dev_stat_rd  = VEC[i][4];
            dev_stat     = {VEC[i][3], 7'h00};
            cyc();
            rd(3'd3, d);
            chk(d == {30'd0, VEC[i][2:1]}, $sformatf("R2 R3 R7 R8 vec %0d pending", i), d, {30'd0, VEC[i][2:1]});
            chk(host_irq == VEC[i][0], $sformatf("R6 vec %0d irq", i), host_irq, VEC[i][0]);
        end

        // R4 enable readback at both offsets
        rd(3'd5, d); chk(d == 32'h3, "R4 enable read at 5", d, 3);
        rd(3'd7, d); chk(d == 32'h3, "R4 enable read at 7", d, 3);
        // R11 unmapped reads
        rd(3'd2, d); chk(d == 0, "R11 read 2", d, 0);
        rd(3'd4, d); chk(d == 0, "R11 read 4", d, 0);
        rd(3'd6, d); chk(d == 0, "R11 read 6", d, 0);

        // R9 / R10 address capture
        bus_err(64'h1111_2222_3333_4444, 0);
        chk_addr(64'h1111_2222_3333_4444, "R9 first capture");
        bus_err(64'hAAAA_BBBB_CCCC_DDDD, 0);
        chk_addr(64'h1111_2222_3333_4444, "R10 held while pending");
        @(negedge clk); reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'h2; cyc();
        bus_err(64'h5555_6666_7777_8888, 0);
        chk_addr(64'h5555_6666_7777_8888, "R9 capture after clear");
        bus_err(64'h9999_0000_1234_5678, 1);
        chk_addr(64'h9999_0000_1234_5678, "R9 capture with same-cycle clear");
        rd(3'd3, d); chk(d[1] == 1'b1, "R8 bit1 set after clear+error", d, 2);

        // R11 write to unmapped offset leaves captured address
        @(negedge clk); reg_wr = 1; reg_addr = 3'd4; reg_wdata = 32'hFFFF_FFFF; cyc();
        chk_addr(64'h9999_0000_1234_5678, "R11 write 4 no effect");

        // R1 reset clears everything
        @(negedge clk); rst = 1; cyc(); #1 rst = 0;
        chk_addr(64'h0, "R1 reset clears address");
        rd(3'd5, d); chk(d == 0, "R1 reset clears enable", d, 0);
        chk(host_irq == 0, "R1 irq after reset", host_irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule